// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connection Controller

This controller sits on a plug-in card and decides when the card's two-wire bus segment (data and clock) may be joined to the live backplane segment. It samples the four bus lines, an enable input and a supply-good flag through a two-stage synchronizer. From these it drives four control outputs: a link control for the analog pass switches, a precharge-bias enable, a rising-edge accelerator enable and an active-high ready flag. The analog parts are outside this block.

After the supply becomes good, the precharge bias turns on. Enable must then stay high for an initialization interval before the bus watcher is armed. Once armed, the controller waits for one of two backplane qualifiers: a STOP condition, or both backplane lines held high for the idle time. The card lines must also both be high. It then closes the link, turns the precharge off and raises ready. The link stays closed whatever the bus does, until enable drops or the supply fails.

States: `HS_LOCKOUT` (supply not good), `HS_SHUTDOWN` (enable low), `HS_INIT` (initialization interval, precharge on), `HS_WAIT` (armed, precharge on, waiting for a qualifier), `HS_LINKED` (segments joined). Transitions:
- supply_fail: any state to `HS_LOCKOUT`; this has the highest priority.
- power_good_en: `HS_LOCKOUT` to `HS_INIT` when enable is high.
- power_good_dis: `HS_LOCKOUT` to `HS_SHUTDOWN` when enable is low.
- disable: `HS_INIT`, `HS_WAIT` or `HS_LINKED` to `HS_SHUTDOWN` when enable is low.
- reenable: `HS_SHUTDOWN` to `HS_INIT` when enable is high.
- init_done: `HS_INIT` to `HS_WAIT` after the initialization interval.
- join: `HS_WAIT` to `HS_LINKED` when a qualifier is present and both card lines are high.

Top module: `hsw_conn_ctrl`

## Requirements
- R1: While the synchronized supply-good flag is low, link, precharge, accelerator and ready are all low, and bus activity has no effect.
- R2: Once supply is good with enable high, precharge is high. No link can form until enable has been high for INIT_US microseconds, which is the initialization interval.
- R3: When armed, a link forms once either qualifier is present: a pending STOP, or both backplane lines sampled high for IDLE_US microseconds (IDLE_CYCLES clocks) without a break.
- R4: No link forms while either card-side line is low, even when a qualifier is present.
- R5: While linked, link, ready and accelerator are high and precharge is low.
- R6: While linked with supply good and enable high, any activity on either bus segment leaves the link closed.
- R7: Enable low forces link, precharge, accelerator and ready low.
- R8: A STOP is SDA going from 0 to 1 while SCL is 1 in both samples. A START is SDA going from 1 to 0 while SCL is 1 in both samples. A START clears a pending STOP.
- R9: Any backplane line sampled low restarts the idle count from zero.
- R10: When enable returns high after shutdown, precharge turns back on and the full initialization interval runs again before a link can form.
- R11: Each output reflects an input change on the third rising clock edge after the input is first sampled: two synchronizer stages, then one state update. A qualifier is registered one edge further on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above the undervoltage threshold |
| en_i | input | 1 | Enable; low means shutdown and isolation |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| cd_sda_i | input | 1 | Card data line level |
| cd_scl_i | input | 1 | Card clock line level |
| link_o | output | 1 | Close the pass switches between the segments |
| prechg_o | output | 1 | Enable the precharge bias on all bus pins |
| accel_o | output | 1 | Enable the rising-edge accelerators |
| ready_o | output | 1 | Segments joined and traffic may flow |

## Verification
Assertions check on every cycle that a new link always follows a present qualifier with both card lines high. They also check that a closed link survives any bus activity while enabled, that enable low or supply failure clears the outputs on the next state update, and that a low backplane sample clears the idle count. Only the bench scenarios can show the exact length of the initialization and idle intervals and the three-edge output latency. They also show that a START cancels a pending STOP and that re-enabling restarts the initialization. A behavioural model replays every cycle to cover these.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        HS_LOCKOUT  = 3'd0,
        HS_SHUTDOWN = 3'd1,
        HS_INIT     = 3'd2,
        HS_WAIT     = 3'd3,
        HS_LINKED   = 3'd4
    } hs_state_e;

    // bit positions inside the synchronized input vector
    localparam int IDX_SUPPLY = 5;
    localparam int IDX_EN     = 4;
    localparam int IDX_BPSDA  = 3;
    localparam int IDX_BPSCL  = 2;
    localparam int IDX_CDSDA  = 1;
    localparam int IDX_CDSCL  = 0;
    localparam int IN_W       = 6;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/hsw_bus_watch.sv
module hsw_bus_watch #(
    parameter int IDLE_CYCLES = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic qualified_o
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

    logic [CNT_W-1:0] idle_cnt_q;
    logic             stop_pend_q;
    logic             sda_prev_q;
    logic             scl_prev_q;
    logic             bus_high;
    logic             scl_steady;
    logic             stop_evt;
    logic             start_evt;

    assign bus_high   = sda_i && scl_i;
    assign scl_steady = scl_i && scl_prev_q;
    assign stop_evt   = scl_steady && !sda_prev_q && sda_i;
    assign start_evt  = scl_steady && sda_prev_q && !sda_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev_q <= 1'b0;
            scl_prev_q <= 1'b0;
        end else begin
            sda_prev_q <= sda_i;
            scl_prev_q <= scl_i;
        end
    end

    // idle timer: saturates at the terminal count, restarts on any low sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               idle_cnt_q <= '0;
        else if (!arm_i)          idle_cnt_q <= '0;
        else if (!bus_high)       idle_cnt_q <= '0;
        else if (idle_cnt_q != CNT_MAX) idle_cnt_q <= idle_cnt_q + 1'b1;
    end

    // pending STOP, cancelled by a START
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         stop_pend_q <= 1'b0;
        else if (!arm_i)    stop_pend_q <= 1'b0;
        else if (stop_evt)  stop_pend_q <= 1'b1;
        else if (start_evt) stop_pend_q <= 1'b0;
    end

    assign qualified_o = stop_pend_q || (idle_cnt_q == CNT_MAX);

    a_r9_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && !bus_high |=> idle_cnt_q == '0);

    a_r8_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && start_evt |=> !stop_pend_q);

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt_q <= CNT_MAX);

endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
    import hsw_pkg::*;
#(
    parameter int INIT_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic en_i,
    input  logic qual_i,
    input  logic card_high_i,
    output logic armed_o,
    output logic link_o,
    output logic prechg_o,
    output logic accel_o,
    output logic ready_o
);
    localparam int ICW = $clog2(INIT_CYCLES + 1);
    localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_CYCLES - 1);

    hs_state_e        state_q;
    hs_state_e        state_d;
    logic [ICW-1:0]   init_cnt_q;
    logic             init_done;

    assign init_done = (init_cnt_q == INIT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_LOCKOUT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  init_cnt_q <= '0;
        else if (state_q != HS_INIT) init_cnt_q <= '0;
        else if (!init_done)         init_cnt_q <= init_cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (!supply_ok_i) begin
            state_d = HS_LOCKOUT;
        end else begin
            unique case (state_q)
                HS_LOCKOUT:  state_d = en_i ? HS_INIT : HS_SHUTDOWN;
                HS_SHUTDOWN: if (en_i) state_d = HS_INIT;
                HS_INIT: begin
                    if (!en_i)          state_d = HS_SHUTDOWN;
                    else if (init_done) state_d = HS_WAIT;
                end
                HS_WAIT: begin
                    if (!en_i)                       state_d = HS_SHUTDOWN;
                    else if (qual_i && card_high_i)  state_d = HS_LINKED;
                end
                HS_LINKED:   if (!en_i) state_d = HS_SHUTDOWN;
                default:     state_d = HS_LOCKOUT;
            endcase
        end
    end

    always_comb begin
        link_o   = 1'b0;
        prechg_o = 1'b0;
        armed_o  = 1'b0;
        unique case (state_q)
            HS_LOCKOUT, HS_SHUTDOWN: ;
            HS_INIT:   prechg_o = 1'b1;
            HS_WAIT: begin
                prechg_o = 1'b1;
                armed_o  = 1'b1;
            end
            HS_LINKED: link_o = 1'b1;
            default: ;
        endcase
        accel_o = link_o;
        ready_o = link_o;
    end

    a_r1_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !link_o && !prechg_o && !ready_o && !accel_o);

    a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !link_o && !prechg_o && !accel_o && !ready_o);

    a_r6_hold_link: assert property (@(posedge clk) disable iff (!rst_n)
        link_o && en_i && supply_ok_i |=> link_o);

    a_r4_card_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_o) |-> $past(card_high_i));

    a_r2_arm_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(state_q == HS_INIT));

endmodule

// File: rtl/hsw_conn_ctrl.sv
module hsw_conn_ctrl
    import hsw_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int IDLE_US     = 120,
    parameter int INIT_US     = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic en_i,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    output logic link_o,
    output logic prechg_o,
    output logic accel_o,
    output logic ready_o
);
    localparam int CYC_PER_US  = CLK_FREQ_HZ / 1_000_000;
    localparam int IDLE_CYCLES = CYC_PER_US * IDLE_US;
    localparam int INIT_CYCLES = CYC_PER_US * INIT_US;

    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] syn_in;
    logic            armed;
    logic            qual;
    logic            card_high;

    assign raw_in = {supply_ok_i, en_i, bp_sda_i, bp_scl_i, cd_sda_i, cd_scl_i};

    hsw_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign card_high = syn_in[IDX_CDSDA] && syn_in[IDX_CDSCL];

    hsw_bus_watch #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (armed),
        .sda_i       (syn_in[IDX_BPSDA]),
        .scl_i       (syn_in[IDX_BPSCL]),
        .qualified_o (qual)
    );

    hsw_fsm #(
        .INIT_CYCLES (INIT_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (syn_in[IDX_SUPPLY]),
        .en_i        (syn_in[IDX_EN]),
        .qual_i      (qual),
        .card_high_i (card_high),
        .armed_o     (armed),
        .link_o      (link_o),
        .prechg_o    (prechg_o),
        .accel_o     (accel_o),
        .ready_o     (ready_o)
    );

    a_r3_join_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_o) |-> $past(qual));

    a_r5_linked_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_o) |-> ready_o && accel_o && !prechg_o);

endmodule

// File: tb/hsw_conn_ctrl_test.sv
module hsw_conn_ctrl_test;
    localparam int IDLE_C = 120;   // 1 MHz count base: 120 us -> 120 clocks
    localparam int INIT_C = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b0, en = 1'b0, bsda = 1'b0, bscl = 1'b0, csda = 1'b0, cscl = 1'b0;
    logic link, prechg, accel, ready;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    hsw_conn_ctrl #(.CLK_FREQ_HZ(1_000_000), .IDLE_US(120), .INIT_US(50)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(sup), .en_i(en),
        .bp_sda_i(bsda), .bp_scl_i(bscl), .cd_sda_i(csda), .cd_scl_i(cscl),
        .link_o(link), .prechg_o(prechg), .accel_o(accel), .ready_o(ready));

    // ---------------- behavioural reference ----------------
    // model states: 0 lockout, 1 off, 2 init, 3 wait, 4 linked
    logic [5:0] hist[$];
    int m_st = 0, m_cnt = 0, m_init = 0;
    bit m_stop = 0, m_psda = 0, m_pscl = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {6'd0, 6'd0};
            m_st = 0; m_cnt = 0; m_init = 0; m_stop = 0; m_psda = 0; m_pscl = 0;
        end else begin
            logic [5:0] u;
            int n_st, n_cnt;
            bit n_stop, qual, s_ok, e_ok, bd, bc, card;
            hist.push_back({sup, en, bsda, bscl, csda, cscl});
            u = hist.pop_front();
            s_ok = u[5]; e_ok = u[4]; bd = u[3]; bc = u[2]; card = u[1] && u[0];
            qual = m_stop || (m_cnt == IDLE_C);
            n_cnt = 0; n_stop = 0;
            if (m_st == 3) begin
                n_cnt = (bd && bc) ? ((m_cnt < IDLE_C) ? m_cnt + 1 : m_cnt) : 0;
                n_stop = m_stop;
                if (bc && m_pscl && !m_psda && bd) n_stop = 1;
                else if (bc && m_pscl && m_psda && !bd) n_stop = 0;
            end
            n_st = m_st;
            if (!s_ok) n_st = 0;
            else case (m_st)
                0: n_st = e_ok ? 2 : 1;
                1: if (e_ok) n_st = 2;
                2: if (!e_ok) n_st = 1; else if (m_init == INIT_C - 1) n_st = 3;
                3: if (!e_ok) n_st = 1; else if (qual && card) n_st = 4;
                default: if (!e_ok) n_st = 1;
            endcase
            m_init = (m_st == 2 && m_init < INIT_C - 1) ? m_init + 1 : ((m_st == 2) ? m_init : 0);
            m_st = n_st; m_cnt = n_cnt; m_stop = n_stop; m_psda = bd; m_pscl = bc;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            bit e_link, e_pre;
            e_link = (m_st == 4);
            e_pre = (m_st == 2 || m_st == 3);
            n_checks++;
            if ({link, ready, accel, prechg} !== {e_link, e_link, e_link, e_pre}) begin
                n_errors++;
                $display("FAIL %s cycle %0d: link/ready/accel/prechg = %b%b%b%b expected %b%b%b%b",
                         cur_req, cycles, link, ready, accel, prechg, e_link, e_link, e_link, e_pre);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic bp(input logic d, input logic c);
        bsda = d; bscl = c;
    endtask

    // watchdog
    initial begin
        #200000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        tick(3);
        chk(link, 1'b0, "R1", "reset link");
        chk(prechg, 1'b0, "R1", "reset precharge");
        rst_n = 1'b1;
        // R1: bus activity while supply is bad
        en = 1; csda = 1; cscl = 1;
        for (int i = 0; i < 20; i++) begin bp(i[0], i[1]); tick(1); end
        chk(link, 1'b0, "R1", "lockout link");
        chk(prechg, 1'b0, "R1", "lockout precharge");

        // R2/R3: power good, idle bus
        cur_req = "R2";
        bp(1, 1); sup = 1;
        tick(3);
        chk(prechg, 1'b1, "R2", "precharge on after supply good (R11 latency)");
        tick(INIT_C + IDLE_C - 10);
        chk(link, 1'b0, "R2", "no link before init+idle");
        cur_req = "R3";
        tick(15);
        chk(link, 1'b1, "R3", "link after idle time");
        chk(ready, 1'b1, "R5", "ready while linked");
        chk(accel, 1'b1, "R5", "accelerator while linked");
        chk(prechg, 1'b0, "R5", "precharge off while linked");

        // R6: traffic on both sides
        cur_req = "R6";
        for (int i = 0; i < 40; i++) begin bp(i[1], i[0]); csda = i[2]; cscl = i[0]; tick(1); end
        chk(link, 1'b1, "R6", "link held through traffic");

        // R7: disable
        cur_req = "R7";
        en = 0; tick(3);
        chk(link, 1'b0, "R7", "link dropped");
        chk(ready, 1'b0, "R7", "ready dropped");
        chk(prechg, 1'b0, "R7", "precharge off in shutdown");
        tick(10);

        // R10: re-enable restarts init; R9: short lows keep restarting idle
        cur_req = "R10";
        bp(1, 1); csda = 1; cscl = 1; en = 1;
        tick(3);
        chk(prechg, 1'b1, "R10", "precharge back on");
        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin tick(100); bscl = 0; tick(1); bscl = 1; end
        chk(link, 1'b0, "R9", "idle restarted by low clock samples");

        // R4/R8: STOP with card busy
        cur_req = "R4";
        csda = 0;
        bp(0, 1); tick(4); bp(1, 1); tick(10);
        chk(link, 1'b0, "R4", "no link with card data low");
        cur_req = "R8";
        csda = 1; tick(5);
        chk(link, 1'b1, "R8", "link soon after STOP once card high");

        // R8: START cancels pending STOP
        en = 0; tick(5); en = 1; tick(INIT_C + 10);
        csda = 0;
        bp(0, 1); tick(3); bp(1, 1); tick(3); bp(0, 1); tick(3);
        csda = 1;
        for (int i = 0; i < 30; i++) begin bscl = i[0]; tick(1); end
        chk(link, 1'b0, "R8", "START cancelled STOP");
        cur_req = "R3";
        bp(1, 1); tick(IDLE_C + 6);
        chk(link, 1'b1, "R3", "link after idle following START");

        // R1: supply failure while linked
        cur_req = "R1";
        sup = 0; tick(3);
        chk(link, 1'b0, "R1", "supply fail drops link");
        chk(prechg, 1'b0, "R1", "supply fail precharge off");
        tick(5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule